// File: doc/BRIEF.md
# UART Sampling Tick Generator

This block turns a single reference clock into the 16x sampling tick that a UART transmitter and receiver share. One serial bit time lasts sixteen ticks. The tick is a one-cycle enable pulse in the reference clock domain, not a derived clock, so everything downstream stays on one clock.

The rate is set by two stages. The first is a prescaler that divides the reference clock by 1 or by 4. The second is a 16-bit divisor counter that divides the prescaled rate. The divisor to program is the reference frequency divided by the prescaler ratio, divided by sixteen times the bit rate. With a 14.7456 MHz reference, a divisor of 1 gives 921.6k bit/s at ratio 1 and 230.4k bit/s at ratio 4. A divisor of 0x0060 gives 9600 or 2400 bit/s, and 0x0900 gives 400 or 100 bit/s.

Firmware programs the block through a single-cycle write strobe, an address and a data byte. The divisor is written as two independent byte registers, and a control register holds the prescaler select.

Top module: `sample_tick_gen`

## Requirements
- R1: The reset is synchronous and active high. While it is held, `tick` is low. Reset leaves the divisor at 0x0001 and the prescaler at divide-by-1, so `tick` is high on every cycle once reset is released.
- R2: When the period (effective divisor times prescaler ratio) is greater than 1, every tick lasts exactly one clock cycle and is followed by a low cycle.
- R3: With the prescaler select at 0, `tick` repeats every D cycles, where D is the effective divisor.
- R4: With the prescaler select at 1, `tick` repeats every 4*D cycles.
- R5: Address 0 writes the low divisor byte and address 1 writes the high divisor byte. A write to one byte leaves the other byte unchanged.
- R6: A write to address 0, 1 or 2 restarts both counters at the write edge. `tick` is low in the following cycle, and the first new tick appears exactly one period after the write edge.
- R7: A divisor value of 0 is treated as 1.
- R8: Address 2 is the control register. Data bit 0 selects the prescaler (0 = divide by 1, 1 = divide by 4), and data bits 7:1 are ignored.
- R9: A write to address 3 changes no setting and does not disturb the running tick cadence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 2 | Register select: 0 divisor low, 1 divisor high, 2 control, 3 unused |
| wr_data | input | 8 | Write data byte |
| tick | output | 1 | Registered 16x sampling enable, one cycle wide |

## Verification
The bench builds the block with its default parameters: a 16-bit divisor split into two 8-bit bytes, and a prescaler ratio of 4. These values make the full byte-wise register map and both prescaler ratios reachable. They also allow the 0x0900 divisor at ratio 4 to be checked, which gives a period of 9216 cycles. Random divisors are kept below 512 so that many reloads, partial byte writes and control values with junk upper bits fit into the run. The upper half of the 16-bit range is covered only by the bound assertions, not by measured periods.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;
  typedef enum logic {
    PRE_DIV1 = 1'b0,
    PRE_DIVN = 1'b1
  } pre_mode_e;

  localparam int unsigned CTRL_PRE_BIT = 0;
endpackage

// File: rtl/bg_regs.sv
module bg_regs
  import baudgen_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [DIV_W-1:0]  div_eff,
  output pre_mode_e         pre_mode,
  output logic              reload
);
  localparam int NBYTES    = DIV_W / BYTE_W;
  localparam int CTRL_ADDR = NBYTES;

  logic [DIV_W-1:0] div_q;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)
        div_q[g*BYTE_W +: BYTE_W] <= (g == 0) ? BYTE_W'(1) : '0;
      else if (wr_en && wr_addr == ADDR_W'(g))
        div_q[g*BYTE_W +: BYTE_W] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      pre_mode <= PRE_DIV1;
    else if (wr_en && wr_addr == ADDR_W'(CTRL_ADDR))
      pre_mode <= pre_mode_e'(wr_data[CTRL_PRE_BIT]);
  end

  assign div_eff = (div_q == '0) ? DIV_W'(1) : div_q;
  assign reload  = wr_en && (wr_addr <= ADDR_W'(CTRL_ADDR));

  // R7: the divisor seen by the counter is never zero
  assert_div_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
    div_eff != '0);

  // R9: a write to the unused address changes no setting
  assert_rsvd_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr > ADDR_W'(CTRL_ADDR)) |=> ($stable(div_q) && $stable(pre_mode)));

  // R5: a low-byte write keeps the upper byte
  assert_hi_kept_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(0)) |=> $stable(div_q[DIV_W-1:BYTE_W]));
endmodule

// File: rtl/bg_prescaler.sv
module bg_prescaler
  import baudgen_pkg::*;
#(
  parameter int PRE_DIV = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      clr,
  input  pre_mode_e mode,
  output logic      pre_en
);
  localparam int PCW = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
  localparam logic [PCW-1:0] LAST = PCW'(PRE_DIV - 1);

  logic [PCW-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst || clr || mode == PRE_DIV1)
      pcnt <= '0;
    else if (pcnt == LAST)
      pcnt <= '0;
    else
      pcnt <= pcnt + PCW'(1);
  end

  assign pre_en = (mode == PRE_DIV1) || (pcnt == LAST);

  // R4: in divide-by-N mode the prescaler steps by one on each cycle
  assert_pre_step_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == PRE_DIVN && !clr && pcnt != LAST) |=> pcnt == $past(pcnt) + PCW'(1));
endmodule

// File: rtl/bg_divcnt.sv
module bg_divcnt #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);
  logic [DIV_W-1:0] dcnt;
  logic             at_end;

  assign at_end = (dcnt == limit - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      dcnt <= '0;
      tick <= 1'b0;
    end else begin
      tick <= step && at_end;
      if (step)
        dcnt <= at_end ? '0 : dcnt + DIV_W'(1);
    end
  end

  // R3: the count stays below the active divisor
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    dcnt < limit);

  // R6: a reload leaves the counter at zero with the tick low
  assert_reload_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (dcnt == '0 && !tick));
endmodule

// File: rtl/sample_tick_gen.sv
module sample_tick_gen
  import baudgen_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int BYTE_W  = 8,
  parameter int PRE_DIV = 4,
  parameter int ADDR_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              tick
);
  logic [DIV_W-1:0] div_eff;
  pre_mode_e        pre_mode;
  logic             reload;
  logic             pre_en;

  bg_regs #(.DIV_W(DIV_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .div_eff(div_eff), .pre_mode(pre_mode), .reload(reload)
  );

  bg_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst(rst), .clr(reload), .mode(pre_mode), .pre_en(pre_en)
  );

  bg_divcnt #(.DIV_W(DIV_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(reload), .step(pre_en), .limit(div_eff), .tick(tick)
  );

  // R1: no tick while reset is held
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> !tick);

  // R2: a tick is a single cycle unless the period is one cycle
  assert_tick_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && !(pre_mode == PRE_DIV1 && div_eff == DIV_W'(1))) |=> !tick);
endmodule

// File: tb/tb_sample_tick_gen.sv
module tb_sample_tick_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tick;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [7:0] m_lo = 8'd1, m_hi = 8'd0;
  logic       m_sel = 1'b0;

  always #4 clk = ~clk;

  sample_tick_gen dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .tick(tick)
  );

  function automatic int exp_period(input logic [7:0] lo, input logic [7:0] hi, input logic sel);
    int d;
    d = {hi, lo};
    if (d == 0) d = 1;
    return sel ? 4 * d : d;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    case (a)
      2'd0: m_lo = d;
      2'd1: m_hi = d;
      2'd2: m_sel = d[0];
      default: ;
    endcase
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_tick(output int cnt, input int limit);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!tick && cnt < limit);
  endtask

  // Called at the negedge right after a reloading write edge
  task automatic measure(input string req);
    int c;
    int e;
    e = exp_period(m_lo, m_hi, m_sel);
    check(tick == 1'b0, "R6 tick low after reload", tick, 0);
    wait_tick(c, e + 4);
    check(c == e, "R6 first tick one period after write", c, e);
    if (e > 1) begin
      @(negedge clk);
      check(tick == 1'b0, "R2 tick one cycle wide", tick, 0);
      wait_tick(c, e + 4);
      c = c + 1;
      check(c == e, req, c, e);
    end else begin
      @(negedge clk);
      check(tick == 1'b1, req, tick, 1);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
      finish_run();
    end
  end

  initial begin
    int c;
    int unused_seed;
    unused_seed = $urandom(32'd1234);
    repeat (4) @(negedge clk);
    check(tick == 1'b0, "R1 tick low in reset", tick, 0);
    rst = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(tick == 1'b1, "R1 default ticks every cycle", tick, 1);
    end

    // R3: 0x0060 at divide-by-1
    do_write(2'd0, 8'h60); do_write(2'd1, 8'h00); do_write(2'd2, 8'h00);
    measure("R3 period D");
    // R4 and R8: same divisor at divide-by-4
    do_write(2'd2, 8'h01);
    measure("R4 period 4D");
    // R8: upper control bits ignored
    do_write(2'd2, 8'hFE);
    measure("R8 ctrl upper bits ignored");
    // R4: 0x0900 at divide-by-4
    do_write(2'd0, 8'h00); do_write(2'd1, 8'h09); do_write(2'd2, 8'h01);
    measure("R4 period 0x0900 x4");
    // R7: zero divisor behaves as one
    do_write(2'd1, 8'h00); do_write(2'd0, 8'h00); do_write(2'd2, 8'h00);
    measure("R7 zero as one, x1");
    do_write(2'd2, 8'h01);
    measure("R7 zero as one, x4");
    // R5: high-byte write keeps low byte
    do_write(2'd0, 8'h03); do_write(2'd2, 8'h00);
    measure("R5 low byte alone");
    do_write(2'd1, 8'h01);
    measure("R5 high byte keeps low");
    // R9: unused address leaves the cadence alone
    do_write(2'd0, 8'h05); do_write(2'd1, 8'h00);
    measure("R3 period 5");
    do_write(2'd3, 8'hA5);
    wait_tick(c, 10);
    check(c == 4, "R9 unused write ignored", c, 4);

    // Random reloads
    for (int i = 0; i < 20; i++) begin
      int a;
      logic [7:0] d;
      a = $urandom % 3;
      case (a)
        0: d = 8'($urandom % 256);
        1: d = 8'($urandom % 2);
        default: d = 8'($urandom % 256);
      endcase
      do_write(2'(a), d);
      measure(m_sel ? "R4 random period" : "R3 random period");
    end

    done = 1;
    finish_run();
  end
endmodule